// File: doc/BRIEF.md
# Boundary-Scan Data Register Path

This block is the data-register half of an IEEE 1149.1 test port. It contains a one-bit bypass register and a boundary-scan chain made of input cells and output cells. Each output pin has one cell for its data and one for its enable. The block does not contain the TAP state machine or the instruction register. Their results reach it as plain inputs: a 3-bit current instruction and three level strobes (Capture-DR, Shift-DR, Update-DR). The block samples these strobes on the rising edge of the test clock.

The instruction selects which register lies between the serial input and the serial output. It also selects what the pins see. The pins can be driven by the core, by the update stages, or with their output enables forced off. A parameter mask marks some output pins as protected, for example a power-enable or a reset-out pin. A protected pin has shift stages but no update stages, so no scan operation can ever drive it.

Pins without a scan cell, such as oscillator pins, are simply not ports of this block. The chain length counts only the scanned pins. There is no streaming data interface, so there is no valid/ready handshake and no back-pressure: every port is a plain control or data pin.

Top module: `tdr_path`

## Requirements
- R1: On test-logic reset (`trst_n` low), `tdo` and `tdo_oe` are 0 and every update stage holds 0.
  - So, under EXTEST right after reset, every unprotected pad output and pad enable reads 0.
- R2: The bypass register is selected for every instruction code except EXTEST (3'b000) and SAMPLE/PRELOAD (3'b001). The named bypass-path codes are BYPASS 3'b111, HIGHZ 3'b010 and CLAMP 3'b100; unused codes such as 3'b110 also select bypass.
  - The bypass register loads 0 in Capture-DR.
  - The first bit shifted out is therefore 0, and each later bit equals the `tdi` bit from one TCK earlier.
- R3: Under EXTEST or SAMPLE/PRELOAD, the boundary chain of length L = N_IN + 2*N_OUT forms the serial path. Chain bit 0 leaves on `tdo` first, and `tdi` enters at bit L-1. After L shifts, the chain holds the L bits fed in.
- R4: In Capture-DR with the boundary chain selected, the chain loads a fixed layout:
  - bits [N_IN-1:0] load `pad_in`;
  - bits [N_IN+N_OUT-1:N_IN] load the driven `pad_out`;
  - bits [L-1:N_IN+N_OUT] load the driven `pad_oe`.
- R5: Under SAMPLE/PRELOAD, `pad_out` equals `core_out` and `pad_oe` equals `core_oe` at all times, including while the chain shifts.
- R6: Under EXTEST, each unprotected pin drives its update stages (data and enable). It ignores the core values and `pad_in`.
- R7: Update stages load from the matching chain bits only on Update-DR under EXTEST or SAMPLE/PRELOAD. Under CLAMP, a full capture, shift and update cycle leaves the update stages unchanged.
- R8: Under CLAMP, each unprotected pin drives its existing update-stage data and enable.
- R9: Under HIGHZ, every unprotected `pad_oe` bit is 0 and `pad_out` follows `core_out`.
- R10: A protected output pin (a bit set in PROT_MASK) always follows `core_out` and `core_oe`, under every instruction including EXTEST and CLAMP.
- R11: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 exactly during the half-cycles that follow a falling edge at which Shift-DR was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| tdi | input | 1 | Serial test data in |
| instr | input | 3 | Current decoded instruction code |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdo | output | 1 | Serial test data out, retimed on falling TCK |
| tdo_oe | output | 1 | Serial output enable |
| pad_in | input | N_IN | Values arriving from input pads |
| core_out | input | N_OUT | Output data from core logic |
| core_oe | input | N_OUT | Output enables from core logic |
| pad_out | output | N_OUT | Data driven to output pads |
| pad_oe | output | N_OUT | Enables driven to output pads |

## Verification
The bench runs full capture/shift/update scans under every instruction code. Random core values, pad inputs and serial data are mixed with a few directed sequences.

Comparing the shifted-out bits against a model does two things. It separates the bypass path (a leading 0, then a one-bit delay) from the boundary path (the captured pin snapshot in the stated bit layout). It also checks that capture sees the driven pin value rather than the core value.

Each scan is followed by a check of the pins against the model's update stages. This check separates EXTEST and CLAMP driving from pass-through, detects a HIGHZ enable that is not forced off, and detects a protected pin that leaks scan data. A directed preload-then-CLAMP sequence shows that a CLAMP scan leaves the update stages untouched.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  typedef enum logic [2:0] {
    INS_EXTEST = 3'b000,
    INS_SAMPLE = 3'b001,
    INS_HIGHZ  = 3'b010,
    INS_CLAMP  = 3'b100,
    INS_IDCODE = 3'b110,
    INS_BYPASS = 3'b111
  } tdr_instr_e;

  function automatic logic uses_chain(logic [2:0] code);
    return (code == INS_EXTEST) || (code == INS_SAMPLE);
  endfunction

  function automatic logic drives_from_update(logic [2:0] code);
    return (code == INS_EXTEST) || (code == INS_CLAMP);
  endfunction

endpackage

// File: rtl/tdr_decode.sv
module tdr_decode
  import tdr_pkg::*;
(
  input  logic [2:0] instr,
  output logic       sel_chain,
  output logic       drive_upd,
  output logic       force_hiz
);
  always_comb begin
    sel_chain = uses_chain(instr);
    drive_upd = drives_from_update(instr);
    force_hiz = (instr == INS_HIGHZ);
  end
endmodule

// File: rtl/tdr_bypass.sv
module tdr_bypass (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic capture,
  input  logic shift,
  output logic q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      q <= 1'b0;
    else if (capture) q <= 1'b0;
    else if (shift)   q <= tdi;
  end
endmodule

// File: rtl/tdr_bsr_chain.sv
module tdr_bsr_chain #(
  parameter int LEN = 12
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tdi,
  input  logic           capture,
  input  logic           shift,
  input  logic [LEN-1:0] par_in,
  output logic [LEN-1:0] q
);
  // Shift direction: bit LEN-1 takes tdi, bit 0 feeds the serial output.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      q <= '0;
    else if (capture) q <= par_in;
    else if (shift)   q <= {tdi, q[LEN-1:1]};
  end
endmodule

// File: rtl/tdr_out_cell.sv
module tdr_out_cell #(
  parameter bit PROTECTED = 1'b0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic upd_en,
  input  logic sh_data,
  input  logic sh_oe,
  input  logic core_out,
  input  logic core_oe,
  input  logic drive_upd,
  input  logic force_hiz,
  output logic pad_out,
  output logic pad_oe,
  output logic upd_data,
  output logic upd_oe
);
  generate
    if (PROTECTED) begin : g_guarded
      // No update stage: scan contents can never reach this pin.
      logic unused_guard;
      assign unused_guard = ^{tck, trst_n, upd_en, sh_data, sh_oe,
                              drive_upd, force_hiz};
      assign upd_data = 1'b0;
      assign upd_oe   = 1'b0;
      assign pad_out  = core_out;
      assign pad_oe   = core_oe;
    end else begin : g_normal
      logic ud_q, uo_q;

      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
          ud_q <= 1'b0;
          uo_q <= 1'b0;
        end else if (upd_en) begin
          ud_q <= sh_data;
          uo_q <= sh_oe;
        end
      end

      assign upd_data = ud_q;
      assign upd_oe   = uo_q;

      always_comb begin
        if (drive_upd) begin
          pad_out = ud_q;
          pad_oe  = uo_q;
        end else if (force_hiz) begin
          pad_out = core_out;
          pad_oe  = 1'b0;
        end else begin
          pad_out = core_out;
          pad_oe  = core_oe;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tdr_tdo.sv
module tdr_tdo (
  input  logic tck,
  input  logic trst_n,
  input  logic shift,
  input  logic ser,
  output logic tdo,
  output logic tdo_oe
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift;
      if (shift) tdo <= ser;
    end
  end
endmodule

// File: rtl/tdr_path.sv
module tdr_path #(
  parameter int              N_IN      = 4,
  parameter int              N_OUT     = 4,
  parameter logic [N_OUT-1:0] PROT_MASK = 4'b1000
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic [2:0]       instr,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pad_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int L      = N_IN + 2 * N_OUT;
  localparam int DATA_LO = N_IN;
  localparam int OE_LO   = N_IN + N_OUT;

  logic sel_chain, drive_upd, force_hiz;
  logic byp_q;
  logic [L-1:0] chain_q;
  logic [N_OUT-1:0] upd_data, upd_oe;
  logic [2*N_OUT-1:0] upd_q;
  logic ser;

  tdr_decode u_dec (
    .instr     (instr),
    .sel_chain (sel_chain),
    .drive_upd (drive_upd),
    .force_hiz (force_hiz)
  );

  tdr_bypass u_byp (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .capture (capture_dr & ~sel_chain),
    .shift   (shift_dr & ~sel_chain),
    .q       (byp_q)
  );

  tdr_bsr_chain #(.LEN(L)) u_chain (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .capture (capture_dr & sel_chain),
    .shift   (shift_dr & sel_chain),
    .par_in  ({pad_oe, pad_out, pad_in}),
    .q       (chain_q)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    tdr_out_cell #(.PROTECTED(PROT_MASK[i])) u_cell (
      .tck       (tck),
      .trst_n    (trst_n),
      .upd_en    (update_dr & sel_chain),
      .sh_data   (chain_q[DATA_LO + i]),
      .sh_oe     (chain_q[OE_LO + i]),
      .core_out  (core_out[i]),
      .core_oe   (core_oe[i]),
      .drive_upd (drive_upd),
      .force_hiz (force_hiz),
      .pad_out   (pad_out[i]),
      .pad_oe    (pad_oe[i]),
      .upd_data  (upd_data[i]),
      .upd_oe    (upd_oe[i])
    );
  end

  assign upd_q = {upd_oe, upd_data};
  assign ser   = sel_chain ? chain_q[0] : byp_q;

  tdr_tdo u_tdo (
    .tck    (tck),
    .trst_n (trst_n),
    .shift  (shift_dr),
    .ser    (ser),
    .tdo    (tdo),
    .tdo_oe (tdo_oe)
  );
endmodule

// File: rtl/tdr_path_chk.sv
module tdr_path_chk
  import tdr_pkg::*;
#(
  parameter int               N_OUT     = 4,
  parameter logic [N_OUT-1:0] PROT_MASK = 4'b1000
) (
  input logic               tck,
  input logic               trst_n,
  input logic [2:0]         instr,
  input logic               capture_dr,
  input logic [N_OUT-1:0]   core_out,
  input logic [N_OUT-1:0]   core_oe,
  input logic [N_OUT-1:0]   pad_out,
  input logic [N_OUT-1:0]   pad_oe,
  input logic               byp_q,
  input logic [2*N_OUT-1:0] upd_q
);
  AST_BYPASS_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && !uses_chain(instr)) |=> (byp_q == 1'b0)); // R2

  AST_SAMPLE_PASSTHRU: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == INS_SAMPLE) |-> (pad_out == core_out && pad_oe == core_oe)); // R5

  AST_CLAMP_KEEPS_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == INS_CLAMP) |=> $stable(upd_q)); // R7

  AST_HIGHZ_OE_OFF: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == INS_HIGHZ) |-> ((pad_oe & ~PROT_MASK) == '0)); // R9

  AST_PROTECTED_FOLLOW: assert property (@(posedge tck) disable iff (!trst_n)
    (((pad_out ^ core_out) | (pad_oe ^ core_oe)) & PROT_MASK) == '0); // R10
endmodule

bind tdr_path tdr_path_chk #(.N_OUT(N_OUT), .PROT_MASK(PROT_MASK)) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .instr      (instr),
  .capture_dr (capture_dr),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .byp_q      (byp_q),
  .upd_q      (upd_q)
);

// File: tb/tdr_path_bench.sv
module tdr_path_bench;
  localparam int N_IN = 4;
  localparam int N_OUT = 4;
  localparam logic [N_OUT-1:0] PROT = 4'b1000;
  localparam int L = N_IN + 2 * N_OUT;

  localparam logic [2:0] C_EXTEST = 3'b000, C_SAMPLE = 3'b001, C_HIGHZ = 3'b010,
                         C_CLAMP = 3'b100, C_IDCODE = 3'b110, C_BYPASS = 3'b111;

  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic [2:0] instr = C_BYPASS;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic tdo, tdo_oe;
  logic [N_IN-1:0] pad_in = '0;
  logic [N_OUT-1:0] core_out = '0, core_oe = '0;
  logic [N_OUT-1:0] pad_out, pad_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [N_OUT-1:0] m_ud = '0, m_uo = '0;

  always #10 tck = ~tck;

  tdr_path #(.N_IN(N_IN), .N_OUT(N_OUT), .PROT_MASK(PROT)) u_tdr_path (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .instr(instr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdo(tdo), .tdo_oe(tdo_oe), .pad_in(pad_in), .core_out(core_out),
    .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*N_OUT-1:0] exp_pads(logic [2:0] ins);
    logic [N_OUT-1:0] o, e;
    for (int i = 0; i < N_OUT; i++) begin
      if (PROT[i]) begin o[i] = core_out[i]; e[i] = core_oe[i]; end
      else if (ins == C_EXTEST || ins == C_CLAMP) begin o[i] = m_ud[i]; e[i] = m_uo[i]; end
      else if (ins == C_HIGHZ) begin o[i] = core_out[i]; e[i] = 1'b0; end
      else begin o[i] = core_out[i]; e[i] = core_oe[i]; end
    end
    return {e, o};
  endfunction

  function automatic bit on_chain(logic [2:0] ins);
    return ins == C_EXTEST || ins == C_SAMPLE;
  endfunction

  task automatic check_pads(logic [2:0] ins, string tag);
    logic [2*N_OUT-1:0] ex;
    ex = exp_pads(ins);
    chk({pad_oe, pad_out} == ex, tag, {pad_oe, pad_out}, ex);
  endtask

  // Caller is 2 ns after a rising edge. Returns 2 ns after a rising edge.
  task automatic scan(logic [2:0] ins, logic [L-1:0] din);
    logic [L-1:0] dout, ex;
    logic [2*N_OUT-1:0] pads;
    instr = ins;
    #1;
    pads = exp_pads(ins);
    if (on_chain(ins)) ex = {pads, pad_in};               // R4 layout
    else ex = {din[L-2:0], 1'b0};                          // R2 leading zero
    capture_dr = 1'b1;
    @(posedge tck); #2;
    capture_dr = 1'b0;
    for (int i = 0; i < L; i++) begin
      shift_dr = 1'b1;
      tdi = din[i];
      if (i == 0) chk(tdo_oe == 1'b0, "R11 oe before fall", tdo_oe, 0);
      @(negedge tck); #5;
      dout[i] = tdo;
      if (i == 0) chk(tdo_oe == 1'b1, "R11 oe after fall", tdo_oe, 1);
      @(posedge tck); #2;
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    @(posedge tck); #2;
    update_dr = 1'b0;
    chk(dout == ex, on_chain(ins) ? "R3/R4 chain out" : "R2 bypass out", dout, ex);
    if (on_chain(ins))                                     // R7 model
      for (int i = 0; i < N_OUT; i++)
        if (!PROT[i]) begin
          m_ud[i] = din[N_IN + i];
          m_uo[i] = din[N_IN + N_OUT + i];
        end
    @(negedge tck); #5;
    chk(tdo_oe == 1'b0, "R11 oe idle", tdo_oe, 0);
    check_pads(ins, "R5/R6/R8/R9/R10 pads");
    @(posedge tck); #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [6];
    logic [L-1:0] pre;
    void'($urandom(32'd5511));
    codes = '{C_EXTEST, C_SAMPLE, C_HIGHZ, C_CLAMP, C_IDCODE, C_BYPASS};
    #55;
    // R1: reset state
    chk(tdo == 1'b0 && tdo_oe == 1'b0, "R1 tdo reset", {tdo, tdo_oe}, 0);
    trst_n = 1'b1;
    @(posedge tck); #2;
    instr = C_EXTEST; core_out = '1; core_oe = '1;
    #1;
    chk(((pad_out | pad_oe) & ~PROT) == '0, "R1 update reset", {pad_oe, pad_out}, 0);
    check_pads(C_EXTEST, "R10 protected under EXTEST");

    // R7/R8: preload a pattern, then a CLAMP scan must not disturb it
    core_out = 4'b0101; core_oe = 4'b0011; pad_in = 4'b1001;
    pre = 12'b0110_1010_0000;
    scan(C_SAMPLE, pre);
    scan(C_EXTEST, 12'hA5C);                                // R6
    scan(C_SAMPLE, pre);
    scan(C_CLAMP, 12'h3F0);
    check_pads(C_CLAMP, "R8 clamp drives preload");
    instr = C_EXTEST; #1;
    check_pads(C_EXTEST, "R7 update untouched by clamp");

    // R9: HIGHZ with all core enables set
    core_oe = '1;
    scan(C_HIGHZ, 12'hFFF);
    // R2: unused code selects bypass
    scan(C_IDCODE, 12'h5A5);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      core_out = N_OUT'($urandom);
      core_oe  = N_OUT'($urandom);
      pad_in   = N_IN'($urandom);
      scan(codes[$urandom % 6], L'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule